// File: doc/BRIEF.md
# Doorbell-Driven Ring Occupancy Tracker

This block holds the DMA-side count of entries waiting in one ring queue. Producers announce new entries by writing a signed 8-bit doorbell value. A positive value is added to the count. A negative value is a pop request that this side does not track, so the count is left as it is. The DMA engine pulses a consume strobe for each entry it takes, and the count drops by one for each pulse while it is non-zero. The count is a plain modular counter that wraps with no saturation and no overflow flag.

A reset of the ring on the queue-manager side does not touch this count. Only the tracker's own synchronous reset clears it. After an outside ring reset, the count is brought back to zero by sending doorbells until it wraps. A ring-mode input selects how the count relates to the queue-side element count. In the paired modes, every producer write places two elements in the queue but moves this counter by only one.

Top module: `ring_occ_tracker`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, `occ_count` becomes 0 and `has_entries` becomes low after that edge.
- R2: A doorbell write (`db_we` high) whose `db_count` is +1 to +127 in 8-bit two's complement adds that value to `occ_count`, visible after the same clock edge.
- R3: A doorbell value of 0, a negative doorbell value (-1 to -128, bit 7 set), or any value while `db_we` is low leaves `occ_count` unchanged.
- R4: `occ_count` is 21 bits wide and wraps modulo 2^21. 2^21-1 plus 1 gives 0, and repeated doorbells can bring any count back to exactly 0.
- R5: A `consume` pulse lowers `occ_count` by one when it is non-zero. At zero, `consume` has no effect.
- R6: A positive doorbell and `consume` in the same cycle change `occ_count` by the doorbell value minus one. The minus one applies only if `occ_count` was non-zero before the edge.
- R7: `qm_ring_reset` has no effect on `occ_count` or `has_entries`.
- R8: `has_entries` is high exactly when `occ_count` is non-zero.
- R9: `elem_count` equals `occ_count` for `ring_mode` 0 (exposed) and 1 (messaging). It equals twice `occ_count` for `ring_mode` 2 (credentials) and 3 (queue-manager). It is 22 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| db_we | input | 1 | Doorbell write strobe |
| db_count | input | 8 | Signed doorbell count, two's complement |
| consume | input | 1 | DMA engine took one entry |
| qm_ring_reset | input | 1 | Queue-manager-side ring reset, ignored by the count |
| ring_mode | input | 2 | 0 exposed, 1 messaging, 2 credentials, 3 queue-manager |
| occ_count | output | 21 | Current tracked count |
| elem_count | output | 22 | Queue-side element equivalent of the count |
| has_entries | output | 1 | Count is non-zero |

## Verification
The assertions assume that `db_we`, `db_count`, `consume` and `qm_ring_reset` are stable and known at every rising edge once reset is released. They also assume that `ring_mode` holds one of its four defined codes. The bench changes every input only on the falling edge and sets each input to a defined value before reset is released. It holds `ring_mode` fixed while it checks each mode, so the element-count relation is sampled with no mode change in flight.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [1:0] {
        MODE_EXPOSED   = 2'd0,
        MODE_MESSAGING = 2'd1,
        MODE_CREDENT   = 2'd2,
        MODE_QUEUEMGR  = 2'd3
    } ring_mode_e;

    // True when each producer write places two queue elements.
    function automatic logic mode_is_paired(input ring_mode_e m);
        logic paired;
        unique case (m)
            MODE_EXPOSED:   paired = 1'b0;
            MODE_MESSAGING: paired = 1'b0;
            MODE_CREDENT:   paired = 1'b1;
            MODE_QUEUEMGR:  paired = 1'b1;
            default:        paired = 1'b0;
        endcase
        return paired;
    endfunction

endpackage

// File: rtl/occ_db_decode.sv
module occ_db_decode #(
    parameter int CNT_W = 21,
    parameter int DB_W  = 8
) (
    input  logic             db_we,
    input  logic [DB_W-1:0]  db_count,
    output logic             add_en,
    output logic [CNT_W-1:0] add_amt
);
    localparam int MAG_W = DB_W - 1;
    localparam int PAD_W = CNT_W - MAG_W;

    logic             sign_bit;
    logic [MAG_W-1:0] magnitude;

    always_comb begin
        sign_bit  = db_count[DB_W-1];
        magnitude = db_count[MAG_W-1:0];
        // A negative value is a pop request that this side does not track.
        add_en    = db_we && !sign_bit && (magnitude != '0);
        add_amt   = add_en ? {{PAD_W{1'b0}}, magnitude} : '0;
    end

endmodule

// File: rtl/occ_count_reg.sv
module occ_count_reg #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_amt,
    input  logic             consume,
    output logic [CNT_W-1:0] count_o,
    output logic             nonzero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             nonzero;
    } occ_state_t;

    occ_state_t st_d, st_q;
    logic       take_one;

    always_comb begin
        st_d     = st_q;
        take_one = consume && (st_q.count != '0);
        if (add_en || take_one) begin
            st_d.count = st_q.count + add_amt - {{(CNT_W-1){1'b0}}, take_one};
        end
        st_d.nonzero = (st_d.count != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign nonzero_o = st_q.nonzero;

    // R5
    consume_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !add_en && st_q.count == '0) |=> (st_q.count == '0));

endmodule

// File: rtl/occ_elem_scale.sv
module occ_elem_scale #(
    parameter int CNT_W = 21
) (
    input  logic [1:0]     ring_mode,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W:0]   elem_count
);
    import occ_pkg::*;

    ring_mode_e mode;
    logic       paired;

    always_comb begin
        mode       = ring_mode_e'(ring_mode);
        paired     = mode_is_paired(mode);
        elem_count = paired ? {count, 1'b0} : {1'b0, count};
    end

endmodule

// File: rtl/ring_occ_tracker.sv
module ring_occ_tracker #(
    parameter int CNT_W = 21,
    parameter int DB_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_we,
    input  logic [DB_W-1:0]  db_count,
    input  logic             consume,
    input  logic             qm_ring_reset,
    input  logic [1:0]       ring_mode,
    output logic [CNT_W-1:0] occ_count,
    output logic [CNT_W:0]   elem_count,
    output logic             has_entries
);
    localparam int MAG_W = DB_W - 1;

    logic             add_en;
    logic [CNT_W-1:0] add_amt;

    occ_db_decode #(.CNT_W(CNT_W), .DB_W(DB_W)) u_decode (
        .db_we    (db_we),
        .db_count (db_count),
        .add_en   (add_en),
        .add_amt  (add_amt)
    );

    occ_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_en    (add_en),
        .add_amt   (add_amt),
        .consume   (consume),
        .count_o   (occ_count),
        .nonzero_o (has_entries)
    );

    occ_elem_scale #(.CNT_W(CNT_W)) u_scale (
        .ring_mode  (ring_mode),
        .count      (occ_count),
        .elem_count (elem_count)
    );

    // The queue-manager ring reset is observed only by the checks below.
    logic qm_seen;
    assign qm_seen = qm_ring_reset;

    // R2
    pos_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_we && !db_count[DB_W-1] && !consume) |=>
        (occ_count == CNT_W'($past(occ_count) + CNT_W'($past(db_count[MAG_W-1:0])))));

    // R3
    neg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_we && db_count[DB_W-1] && !consume) |=> $stable(occ_count));

    // R7
    qm_reset_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qm_seen && !db_we && !consume) |=> $stable(occ_count));

    // R8
    has_entries_chk: assert property (@(posedge clk) disable iff (!rst_n)
        has_entries == (occ_count != '0));

    // R5
    consume_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !db_we && occ_count != '0) |=>
        (occ_count == CNT_W'($past(occ_count) - 1'b1)));

endmodule

// File: tb/ring_occ_tracker_tb.sv
module ring_occ_tracker_tb_top;
    localparam int CNT_W = 21;
    localparam int MASK  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        db_we = 1'b0;
    logic [7:0]  db_count = 8'd0;
    logic        consume = 1'b0;
    logic        qm_ring_reset = 1'b0;
    logic [1:0]  ring_mode = 2'd0;
    logic [20:0] occ_count;
    logic [21:0] elem_count;
    logic        has_entries;

    int tests = 0;
    int fails = 0;
    int exp_cnt = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ring_occ_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .db_we(db_we), .db_count(db_count),
        .consume(consume), .qm_ring_reset(qm_ring_reset), .ring_mode(ring_mode),
        .occ_count(occ_count), .elem_count(elem_count), .has_entries(has_entries)
    );

    task automatic chk(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(bit we, logic [7:0] v, bit cons, bit qmr);
        db_we = we; db_count = v; consume = cons; qm_ring_reset = qmr;
        @(negedge clk);
        db_we = 0; db_count = 0; consume = 0; qm_ring_reset = 0;
    endtask

    task automatic check_count(string req);
        chk(req, occ_count, exp_cnt);
        chk({req, " has_entries R8"}, has_entries, exp_cnt != 0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        exp_cnt = 0;
        check_count("R1 reset state");
        step(1, 8'd40, 0, 0);
        exp_cnt = 40;
        check_count("R2 before reset");
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        exp_cnt = 0;
        check_count("R1 mid-run reset");
    endtask

    task automatic t_add();
        step(1, 8'd1, 0, 0);   exp_cnt += 1;   check_count("R2 add 1");
        step(1, 8'd127, 0, 0); exp_cnt += 127; check_count("R2 add 127");
        step(1, 8'd9, 0, 0);   exp_cnt += 9;   check_count("R2 add 9");
    endtask

    task automatic t_negative();
        step(1, 8'hFF, 0, 0); check_count("R3 minus 1 ignored");
        step(1, 8'h80, 0, 0); check_count("R3 minus 128 ignored");
        step(1, 8'h00, 0, 0); check_count("R3 zero no-op");
        step(0, 8'd50, 0, 0); check_count("R3 value without strobe");
    endtask

    task automatic t_consume();
        step(0, 0, 1, 0); exp_cnt -= 1; check_count("R5 consume");
        rst_n = 0; @(negedge clk); rst_n = 1; exp_cnt = 0;
        step(0, 0, 1, 0); check_count("R5 consume at zero");
        step(1, 8'd1, 0, 0); exp_cnt = 1;
        step(0, 0, 1, 0); exp_cnt = 0; check_count("R5 consume to zero");
    endtask

    task automatic t_simul();
        step(1, 8'd10, 1, 0); exp_cnt = 10; check_count("R6 add+consume at zero");
        step(1, 8'd5, 1, 0);  exp_cnt = 14; check_count("R6 add+consume non-zero");
        step(1, 8'hF0, 1, 0); exp_cnt = 13; check_count("R6 negative+consume");
    endtask

    task automatic t_qm_reset();
        step(0, 0, 0, 1); check_count("R7 qm reset alone");
        step(0, 0, 0, 1); step(0, 0, 0, 1); check_count("R7 qm reset repeated");
        step(1, 8'd3, 0, 1); exp_cnt += 3; check_count("R7 qm reset with doorbell");
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            ring_mode = 2'(m);
            @(negedge clk);
            chk($sformatf("R9 mode %0d elem_count", m), elem_count,
                (m >= 2) ? 2 * exp_cnt : exp_cnt);
        end
        ring_mode = 2'd0;
    endtask

    task automatic t_wrap();
        rst_n = 0; @(negedge clk); rst_n = 1; exp_cnt = 0;
        for (int i = 0; i < 16513; i++) step(1, 8'd127, 0, 0);
        exp_cnt = MASK;
        check_count("R4 reach max");
        ring_mode = 2'd3; @(negedge clk);
        chk("R9 elem at max paired", elem_count, 2 * longint'(MASK));
        ring_mode = 2'd0;
        step(1, 8'd1, 0, 0); exp_cnt = 0;
        check_count("R4 wrap to zero");
        // Resync after an outside ring reset: count 5, then pad to 2^21.
        step(1, 8'd5, 0, 0);
        step(0, 0, 0, 1); exp_cnt = 5;
        check_count("R7 count kept after qm reset");
        for (int i = 0; i < 16512; i++) step(1, 8'd127, 0, 0);
        step(1, 8'd123, 0, 0); exp_cnt = 0;
        check_count("R4 resync by doorbell wrap");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_add();
        t_negative();
        t_consume();
        t_simul();
        t_qm_reset();
        t_modes();
        t_wrap();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule